// File: doc/BRIEF.md
# Segment Display Frame Timer

This block produces the common-phase and frame timing for a multiplexed segment display. One 8-bit control byte configures it. The byte chooses the frame time source, sets the duty ratio (two, three or four commons, or display off), sets the frame period, and carries a blanking request, a watch-mode keep-alive request and a bias-divider enable flag. The segment drivers downstream take the active common index, a one-cycle frame-start strobe, a display-enabled flag and a blank flag, and from these they select their waveforms.

Two single-cycle tick inputs feed the timing. One is a timebase tick derived from the main oscillator through a fixed divide by 128. The other is a subclock tick. Neither tick passes through the CPU speed-shift path, so changing CPU speed leaves the frame rate unchanged. Three low-power indicators gate the timebase source and decide whether the display survives watch mode. A configuration that cannot work (the timebase chosen while the main oscillator is stopped, or watch keep-alive requested without the subclock) raises an error flag. A change of duty or frame period is deferred to the next frame boundary. Switching the display off acts at once.

Top module: `lcd_frame_timer`

## Requirements
- R1: After reset the control byte reads 0x00, com_idx is 0, and frame_start, disp_en, blank, div_en and cfg_err are all 0.
- R2: A written byte reads back on rd_data from the next cycle on. div_en follows bit 5 and blank follows bit 4.
- R3: Bits 3:2 choose the duty ratio. 01 gives 1/2 duty, 10 gives 1/3 duty and 11 gives 1/4 duty. Once the display is enabled from off, every 2^(F+1) accepted source ticks advance com_idx by one, where F is bits 1:0. After the last common of the mode (index equal to the bits 3:2 value), com_idx wraps to 0.
- R4: When com_idx wraps to 0, frame_start is high for exactly that one cycle. frame_start is 0 at all other times.
- R5: Bit 7 chooses the source. A 0 accepts only tb_tick and a 1 accepts only sub_tick. Pulses on the other tick input do not move com_idx.
- R6: While bit 7 is 0 and either stop_mode or sub_only_mode is high, tb_tick pulses do not move com_idx. Counting resumes once both indicators are low again.
- R7: While watch_mode is high, timing freezes and disp_en is 0, unless bit 6 and bit 7 are both 1. In that case timing keeps running.
- R8: A write with bits 3:2 equal to 00 forces com_idx to 0 and disp_en to 0 in the next cycle. Ticks then have no effect until a non-zero duty is written.
- R9: A duty or frame-period change written while the display runs takes effect at the next wrap of com_idx. Until that wrap the old duty and period continue.
- R10: cfg_err is 1 in two cases. The first is watch_mode high with bit 6 set and bit 7 clear. The second is the display enabled, bit 7 clear, and stop_mode or sub_only_mode high.
- R11: With blank set, the common timing keeps advancing exactly as with blank clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write value |
| rd_data | output | 8 | Control byte readback |
| tb_tick | input | 1 | Timebase tick (main clock divided by 128), one cycle wide |
| sub_tick | input | 1 | Subclock tick, one cycle wide |
| watch_mode | input | 1 | System is in watch mode |
| stop_mode | input | 1 | Main oscillator stopped (main-stop mode) |
| sub_only_mode | input | 1 | Running from subclock only, main oscillator stopped |
| com_idx | output | 2 | Active common index |
| frame_start | output | 1 | One-cycle strobe at each frame wrap |
| disp_en | output | 1 | Display timing active |
| blank | output | 1 | Segments forced to deselect waveform |
| div_en | output | 1 | Bias divider path enable |
| cfg_err | output | 1 | Illegal clock-source and power-mode combination |

## Verification
A full sweep of both sources, all three duty modes and all four frame periods runs two complete frames per setting. Each accepted tick is checked against an arithmetic phase and frame count, so a wrong divide ratio and a wrong wrap point show up as different failures. Each selected-source tick is interleaved with a pulse on the unselected tick input, and that pulse must leave the index unchanged; this separates a source-mux fault from a counting fault. Directed sequences follow: a mid-frame mode change, an immediate switch-off, and each low-power indicator with each legal and illegal source setting. These cover deferral, the off path, gating and the error flag separately.

// File: rtl/lcd_frame_pkg.sv
// Shared control-byte layout and widths for the segment display frame timer.
package lcd_frame_pkg;
    localparam int DUTY_W = 2;               // duty-mode field width
    localparam int PER_W  = 2;               // frame-period field width
    localparam int PRE_W  = 1 << PER_W;      // prescaler width: up to 2^(2^PER_W) ticks

    typedef struct packed {
        logic              src_sub;    // 1: subclock tick, 0: timebase tick
        logic              watch_keep; // keep display alive in watch mode
        logic              div_on;     // bias divider path enable
        logic              blank_req;  // force deselect on segments
        logic [DUTY_W-1:0] duty;       // 00 off, 01..11 = last common index
        logic [PER_W-1:0]  per;        // phase length 2^(per+1) ticks
    } lcd_ctl_t;
endpackage

// File: rtl/lcd_ctl_reg.sv
// Control byte storage plus the active duty/period copy used by the timing.
// Assumes: frame_wrap is a single-cycle pulse from the phase generator.
// A duty of 00 in a write clears the active duty at once; other duty or
// period changes load only while off or at a frame wrap.
module lcd_ctl_reg
    import lcd_frame_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              frame_wrap,
    output lcd_ctl_t          ctl,
    output logic [DUTY_W-1:0] act_duty,
    output logic [PER_W-1:0]  act_per,
    output logic              kill
);
    // Immediate switch-off request from the write port.
    assign kill = wr_en && (wr_data[PER_W +: DUTY_W] == '0);

    // Store the written control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl <= '0;
        else if (wr_en)  ctl <= lcd_ctl_t'(wr_data);
    end

    // Load active duty/period when off or on a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_duty <= '0;
            act_per  <= '0;
        end else if (kill) begin
            act_duty <= '0;
        end else if (act_duty == '0 || frame_wrap) begin
            act_duty <= ctl.duty;
            act_per  <= ctl.per;
        end
    end
endmodule

// File: rtl/lcd_tick_gate.sv
// Picks the frame tick source and applies low-power gating.
// Assumes: the timebase tick exists only while the main oscillator runs;
// the subclock keeps running in every low-power mode handled here.
module lcd_tick_gate (
    input  logic src_sub,
    input  logic watch_keep,
    input  logic disp_on,
    input  logic tb_tick,
    input  logic sub_tick,
    input  logic watch_mode,
    input  logic stop_mode,
    input  logic sub_only_mode,
    output logic tick,
    output logic halt,
    output logic cfg_err
);
    logic main_dead;

    // Main oscillator is unavailable in main-stop and subclock-only modes.
    assign main_dead = stop_mode || sub_only_mode;

    // Source select with timebase suppression while the main oscillator is down.
    assign tick = src_sub ? sub_tick : (tb_tick && !main_dead);

    // Watch mode halts timing unless keep-alive is set with the subclock source.
    assign halt = watch_mode && !(watch_keep && src_sub);

    // Flag combinations that cannot produce a working display.
    assign cfg_err = (watch_mode && watch_keep && !src_sub) ||
                     (disp_on && !src_sub && main_dead);
endmodule

// File: rtl/lcd_phase_gen.sv
// Prescaler and common-index counter for the multiplexed commons.
// Assumes: step is a qualified single-cycle tick; clear wins over step.
// Each common phase lasts 2^(per+1) steps; the index wraps after last_com.
module lcd_phase_gen
    import lcd_frame_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [PER_W-1:0]  per,
    input  logic [DUTY_W-1:0] last_com,
    output logic [DUTY_W-1:0] com,
    output logic              frame_start,
    output logic              wrap
);
    logic [PRE_W-1:0] pre, pre_last;

    // Terminal prescaler count: 2^(per+1)-1 as a thermometer of ones.
    always_comb begin
        for (int i = 0; i < PRE_W; i++) pre_last[i] = (i <= int'(per));
    end

    // Frame wrap: last tick of the last common phase.
    assign wrap = step && (pre == pre_last) && (com == last_com);

    // Advance prescaler and common index; strobe frame_start on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pre         <= '0;
            com         <= '0;
            frame_start <= 1'b0;
        end else begin
            frame_start <= 1'b0;
            if (step) begin
                if (pre == pre_last) begin
                    pre <= '0;
                    if (com == last_com) begin
                        com         <= '0;
                        frame_start <= 1'b1;
                    end else begin
                        com <= com + 1'b1;
                    end
                end else begin
                    pre <= pre + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lcd_frame_timer.sv
// Top of the segment display frame timer.
// Assumes: tick inputs are synchronous single-cycle pulses in the clk domain.
// Ties control storage, source gating and the phase counter together.
module lcd_frame_timer
    import lcd_frame_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       tb_tick,
    input  logic       sub_tick,
    input  logic       watch_mode,
    input  logic       stop_mode,
    input  logic       sub_only_mode,
    output logic [1:0] com_idx,
    output logic       frame_start,
    output logic       disp_en,
    output logic       blank,
    output logic       div_en,
    output logic       cfg_err
);
    lcd_ctl_t          ctl;
    logic [DUTY_W-1:0] act_duty;
    logic [PER_W-1:0]  act_per;
    logic              kill, wrap, tick, halt, disp_on;

    // Display is on whenever an active duty is loaded.
    assign disp_on = (act_duty != '0);

    lcd_ctl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .frame_wrap(wrap), .ctl(ctl), .act_duty(act_duty),
        .act_per(act_per), .kill(kill)
    );

    lcd_tick_gate u_gate (
        .src_sub(ctl.src_sub), .watch_keep(ctl.watch_keep), .disp_on(disp_on),
        .tb_tick(tb_tick), .sub_tick(sub_tick), .watch_mode(watch_mode),
        .stop_mode(stop_mode), .sub_only_mode(sub_only_mode),
        .tick(tick), .halt(halt), .cfg_err(cfg_err)
    );

    lcd_phase_gen u_phase (
        .clk(clk), .rst_n(rst_n), .clear(kill || !disp_on),
        .step(tick && !halt && disp_on), .per(act_per), .last_com(act_duty),
        .com(com_idx), .frame_start(frame_start), .wrap(wrap)
    );

    // Outputs to readback and segment drivers.
    assign rd_data = ctl;
    assign blank   = ctl.blank_req;
    assign div_en  = ctl.div_on;
    assign disp_en = disp_on && !halt;
endmodule

// File: rtl/lcd_frame_timer_chk.sv
// Port-level temporal checks for lcd_frame_timer, attached by bind.
module lcd_frame_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       tb_tick,
    input logic       sub_tick,
    input logic       watch_mode,
    input logic       stop_mode,
    input logic       sub_only_mode,
    input logic [1:0] com_idx,
    input logic       frame_start,
    input logic       disp_en,
    input logic       blank,
    input logic       div_en,
    input logic       cfg_err
);
    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == $past(wr_data));
    p_fs_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);
    p_fs_com0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> com_idx == 2'd0);
    p_tb_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[7] && (stop_mode || sub_only_mode) && !wr_en) |=> $stable(com_idx));
    p_watch_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (watch_mode && !(rd_data[7] && rd_data[6]) && !wr_en) |=> $stable(com_idx));
    p_off_now_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[3:2] == 2'b00) |=> (com_idx == 2'd0 && !disp_en));
    p_err_watch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (watch_mode && rd_data[6] && !rd_data[7]) |-> cfg_err);
endmodule

bind lcd_frame_timer lcd_frame_timer_chk u_chk (.*);

// File: tb/tb_lcd_frame_timer.sv
// Self-checking bench: exhaustive source/duty/period sweep plus directed cases.
module tb_lcd_frame_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       tb_tick = 1'b0, sub_tick = 1'b0;
    logic       watch_mode = 1'b0, stop_mode = 1'b0, sub_only_mode = 1'b0;
    logic [1:0] com_idx;
    logic       frame_start, disp_en, blank, div_en, cfg_err;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    lcd_frame_timer dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic t, input logic s);
        tb_tick = t; sub_tick = s;
        @(negedge clk);
        tb_tick = 1'b0; sub_tick = 1'b0;
    endtask

    task automatic pulses(input int n, input logic t, input logic s);
        for (int i = 0; i < n; i++) pulse(t, s);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1: reset state
        chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
        chk(com_idx == 0 && !frame_start && !disp_en, "R1 timing", com_idx, 0);
        chk(!blank && !div_en && !cfg_err, "R1 flags", {blank, div_en, cfg_err}, 0);

        // R3/R4/R5: sweep source, duty, period over two frames
        for (int c = 0; c < 2; c++)
            for (int m = 1; m < 4; m++)
                for (int f = 0; f < 4; f++) begin
                    int per, tot;
                    logic [1:0] m2, f2;
                    m2 = m[1:0]; f2 = f[1:0];
                    wr(8'h00);
                    wr({c[0], 3'b000, m2, f2});
                    idle();
                    chk(com_idx == 0 && disp_en, "R3 start", com_idx, 0);
                    per = 2 << f;
                    tot = 2 * per * (m + 1);
                    for (int k = 1; k <= tot; k++) begin
                        pulse(c == 1, c == 0);
                        chk(com_idx == ((k - 1) / per) % (m + 1) && !frame_start,
                            "R5 other source", com_idx, ((k - 1) / per) % (m + 1));
                        pulse(c == 0, c == 1);
                        chk(com_idx == (k / per) % (m + 1), "R3 com", com_idx,
                            (k / per) % (m + 1));
                        chk(frame_start == (k % (per * (m + 1)) == 0), "R4 frame_start",
                            frame_start, (k % (per * (m + 1)) == 0));
                    end
                end

        // R9: mid-frame change deferred to wrap
        wr(8'h00); wr(8'h8C); idle();           // sub, duty 11, per 0
        pulses(2, 1'b0, 1'b1);
        wr(8'h85);                              // sub, duty 01, per 1
        pulses(4, 1'b0, 1'b1);
        chk(com_idx == 3, "R9 old duty kept", com_idx, 3);
        pulses(2, 1'b0, 1'b1);
        chk(com_idx == 0 && frame_start, "R9 wrap", com_idx, 0);
        pulses(3, 1'b0, 1'b1);
        chk(com_idx == 0, "R9 new period", com_idx, 0);
        pulse(1'b0, 1'b1);
        chk(com_idx == 1, "R9 new period step", com_idx, 1);
        pulses(4, 1'b0, 1'b1);
        chk(com_idx == 0 && frame_start, "R9 new duty wrap", com_idx, 0);

        // R8: immediate off
        pulses(4, 1'b0, 1'b1);
        chk(com_idx == 1, "R8 pre", com_idx, 1);
        wr(8'h80);
        chk(com_idx == 0 && !disp_en, "R8 off", com_idx, 0);
        pulses(4, 1'b0, 1'b1);
        chk(com_idx == 0 && !disp_en, "R8 stays off", com_idx, 0);

        // R6/R10: timebase gated by stop and subclock-only modes
        wr(8'h0C); idle();
        stop_mode = 1'b1; idle();
        chk(cfg_err, "R10 stop with timebase", cfg_err, 1);
        pulses(4, 1'b1, 1'b0);
        chk(com_idx == 0, "R6 stop", com_idx, 0);
        stop_mode = 1'b0;
        pulses(2, 1'b1, 1'b0);
        chk(com_idx == 1 && !cfg_err, "R6 resume", com_idx, 1);
        sub_only_mode = 1'b1;
        pulses(4, 1'b1, 1'b0);
        chk(com_idx == 1 && cfg_err, "R6 sub_only", com_idx, 1);
        sub_only_mode = 1'b0;

        // R7/R10: watch mode
        wr(8'h4C); idle();                      // timebase, keep set: illegal
        watch_mode = 1'b1; idle();
        chk(cfg_err && !disp_en, "R10 watch keep on timebase", cfg_err, 1);
        pulses(4, 1'b1, 1'b0);
        chk(com_idx == 1, "R7 halt on timebase", com_idx, 1);
        watch_mode = 1'b0;
        wr(8'h00); wr(8'hCC); idle();           // subclock, keep set
        watch_mode = 1'b1;
        pulses(2, 1'b0, 1'b1);
        chk(com_idx == 1 && disp_en && !cfg_err, "R7 keep running", com_idx, 1);
        wr(8'h8C);                              // keep cleared
        pulses(4, 1'b0, 1'b1);
        chk(com_idx == 1 && !disp_en, "R7 halt without keep", com_idx, 1);
        watch_mode = 1'b0;

        // R2/R11: readback, flags, blanking does not stop timing
        wr(8'h00); wr(8'h3C); idle();
        chk(rd_data == 8'h3C, "R2 readback", rd_data, 8'h3C);
        chk(blank && div_en, "R2 flags", {blank, div_en}, 3);
        pulses(2, 1'b1, 1'b0);
        chk(com_idx == 1 && blank, "R11 runs while blank", com_idx, 1);
        pulses(6, 1'b1, 1'b0);
        chk(com_idx == 0 && frame_start, "R11 wrap while blank", com_idx, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule